// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block is the digital sequencer that sits beside a successive-approximation converter's analog front end. It divides the system clock by a selectable power of two to form the converter clock and works internally in half-cycles of that clock. From an enable, a start strobe and a free-running select it schedules the sample-and-hold switch, the conversion window and a one-cycle completion strobe. It also drives the analog multiplexer select and a per-channel mask that marks digital input buffers as disconnected.

The first conversion after enable is long, 25 converter cycles, because it includes an initialisation period. Every later conversion takes 13 cycles. In single mode each conversion needs a start strobe. In free-running mode a new conversion follows each completion with no gap, so samples are evenly spaced. The comparator and the bit search are not modelled. A behavioural stub takes the `ana_in` value held when the switch opens and returns it as the result at completion.

Top module: `sar_seq_top`

## Requirements
- R1: `presc_sel` = s gives a converter clock of the system clock divided by 2^(s+1), that is 2 to 256. One half converter cycle (h) is 2^s system clocks. The divider restarts from zero while `enable` is low.
- R2: When `enable` and `start` arrive in the same cycle, the first conversion raises `done` 51*h system clocks after the edge that samples them, for h of 2 or more. For s=0 this is 52 clocks.
- R3: A start accepted while idle begins the conversion on the next half-cycle tick after the one that registers it, so the start is quantised to a half converter cycle.
- R4: First-conversion schedule, in half-cycles (hc) from its beginning. The switch is open in hc 0, closed in hc 1-3, open in hc 4-25 (initialisation) and closed in hc 26-27. `conv_active` is high with the switch open in hc 28-49.
- R5: A normal conversion is 26 half-cycles. The switch is closed in hc 0-3 and `conv_active` is high in hc 4-25. In single mode after the first conversion, the switch stays closed whenever enabled and not converting.
- R6: With `free_run`=1, each completion starts the next normal conversion at once, giving one `done` every 26*h system clocks.
- R7: `done` is high for exactly one system clock. `result` changes only with `done`, and it equals the `ana_in` value present when `conv_active` rose.
- R8: A `start` strobe while `busy` is high is ignored and causes no further conversion.
- R9: With `free_run`=0, a `chan_wr` write appears on `mux_sel` in the next cycle. With `free_run`=1, the write is held and reaches `mux_sel` only when the next conversion begins.
- R10: A `dis_wr` pulse loads `dis_in` into `dis_mask`, where bit n set means the digital input of channel n is disconnected. Without `dis_wr`, `dis_mask` keeps its value.
- R11: Dropping `enable` aborts the sequence. `busy`, `conv_active` and the switch are low on the next cycle, no `done` follows, and the next enable runs a full first conversion again.
- R12: After reset, `busy`, `done`, `sh_closed`, `conv_active`, `result`, `mux_sel` and `dis_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; low aborts and idles |
| start | input | 1 | Conversion request strobe |
| free_run | input | 1 | 1 = back-to-back conversions |
| presc_sel | input | PSEL_W | Prescaler select, divide by 2^(s+1) |
| chan_wr | input | 1 | Channel register write strobe |
| chan_in | input | CH_W | Channel to select |
| dis_wr | input | 1 | Digital-input mask write strobe |
| dis_in | input | NCH | New digital-input mask |
| ana_in | input | RES_W | Behavioural stand-in for the sampled analog level |
| mux_sel | output | CH_W | Analog multiplexer select |
| dis_mask | output | NCH | Digital input disconnect mask |
| sh_closed | output | 1 | Sample-and-hold switch closed |
| conv_active | output | 1 | Conversion window |
| busy | output | 1 | Start accepted or conversion running |
| done | output | 1 | One-clock completion strobe |
| result | output | RES_W | Conversion result |

## Verification
On every cycle the assertions check that the switch is never closed inside the conversion window and that `done` never lasts two clocks. They also check that the result moves only with `done`, that an abort empties the sequencer one clock later, that free-running completions chain straight into a new conversion, and that the multiplexer holds still through a free-running conversion window. The exact half-cycle positions of the switch edges, the 25- and 13-cycle lengths across prescaler settings, the ignored mid-conversion start and the re-run of the long first conversion after an abort are shown only by the bench's scenarios.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int HCNT_W = 6;

    // half-cycle counts and window positions
    localparam logic [HCNT_W-1:0] FIRST_LAST    = 6'd49;
    localparam logic [HCNT_W-1:0] NORM_LAST     = 6'd25;
    localparam logic [HCNT_W-1:0] FIRST_CONV_LO = 6'd28;
    localparam logic [HCNT_W-1:0] NORM_CONV_LO  = 6'd4;
    localparam logic [HCNT_W-1:0] FIRST_SHA_LO  = 6'd1;
    localparam logic [HCNT_W-1:0] FIRST_SHA_HI  = 6'd3;
    localparam logic [HCNT_W-1:0] FIRST_SHB_LO  = 6'd26;
    localparam logic [HCNT_W-1:0] FIRST_SHB_HI  = 6'd27;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_NORM  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [HCNT_W-1:0]   hcnt;
    } seq_t;

    function automatic logic [HCNT_W-1:0] last_of(seq_t s);
        return (s.phase == PH_FIRST) ? FIRST_LAST : NORM_LAST;
    endfunction

    function automatic logic [HCNT_W-1:0] conv_lo_of(seq_t s);
        return (s.phase == PH_FIRST) ? FIRST_CONV_LO : NORM_CONV_LO;
    endfunction

    function automatic logic in_conv(seq_t s);
        return (s.phase != PH_IDLE) && (s.hcnt >= conv_lo_of(s));
    endfunction

    // switch state implied by the schedule
    function automatic logic sh_sched(seq_t s, logic first_done);
        case (s.phase)
            PH_FIRST: return ((s.hcnt >= FIRST_SHA_LO) && (s.hcnt <= FIRST_SHA_HI)) ||
                             ((s.hcnt >= FIRST_SHB_LO) && (s.hcnt <= FIRST_SHB_HI));
            PH_NORM:  return s.hcnt < NORM_CONV_LO;
            default:  return first_done;
        endcase
    endfunction

endpackage

// File: rtl/sar_presc.sv
module sar_presc #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [PSEL_W-1:0] sel,
    output logic              htick
);
    localparam int PCNT_W = 1 << PSEL_W;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] hmask;

    always_comb hmask = ~({PCNT_W{1'b1}} << sel);

    always_ff @(posedge clk) begin
        if (rst || !en) pcnt <= '0;
        else            pcnt <= pcnt + 1'b1;
    end

    assign htick = en && ((pcnt & hmask) == hmask);
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    input  logic             free_run,
    input  logic             htick,
    input  logic [RES_W-1:0] ana_in,
    output logic             busy,
    output logic             sh_closed,
    output logic             conv_active,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             begin_conv
);
    seq_t              s;
    logic              pend;
    logic              first_done;
    logic [RES_W-1:0]  held;
    logic              at_last;
    logic [HCNT_W-1:0] hnext;

    assign at_last = (s.phase != PH_IDLE) && (s.hcnt == last_of(s));
    assign hnext   = s.hcnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s          <= '{phase: PH_IDLE, hcnt: '0};
            pend       <= 1'b0;
            first_done <= 1'b0;
            done       <= 1'b0;
            held       <= '0;
            result     <= '0;
        end else if (!en) begin
            s          <= '{phase: PH_IDLE, hcnt: '0};
            pend       <= 1'b0;
            first_done <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && (s.phase == PH_IDLE) && !pend)
                pend <= 1'b1;
            if (htick) begin
                if (pend) begin
                    pend    <= 1'b0;
                    s.phase <= first_done ? PH_NORM : PH_FIRST;
                    s.hcnt  <= '0;
                end else if (at_last) begin
                    done       <= 1'b1;
                    result     <= held;
                    first_done <= 1'b1;
                    s.hcnt     <= '0;
                    s.phase    <= free_run ? PH_NORM : PH_IDLE;
                end else if (s.phase != PH_IDLE) begin
                    s.hcnt <= hnext;
                    if (hnext == conv_lo_of(s))
                        held <= ana_in;
                end
            end
        end
    end

    assign busy        = pend || (s.phase != PH_IDLE);
    assign conv_active = in_conv(s);
    assign sh_closed   = en && sh_sched(s, first_done);
    assign begin_conv  = en && htick && (pend || (at_last && free_run));
endmodule

// File: rtl/sar_chan_ctl.sv
module sar_chan_ctl #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            free_run,
    input  logic            load,
    input  logic            chan_wr,
    input  logic [CH_W-1:0] chan_in,
    input  logic            dis_wr,
    input  logic [NCH-1:0]  dis_in,
    output logic [CH_W-1:0] mux_sel,
    output logic [NCH-1:0]  dis_mask
);
    logic [CH_W-1:0] pend_ch;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ch  <= '0;
            mux_sel  <= '0;
            dis_mask <= '0;
        end else begin
            if (chan_wr)
                pend_ch <= chan_in;
            if (!free_run && chan_wr)
                mux_sel <= chan_in;
            else if (free_run && load)
                mux_sel <= pend_ch;
            if (dis_wr)
                dis_mask <= dis_in;
        end
    end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
    parameter int NCH    = 8,
    parameter int RES_W  = 10,
    parameter int PSEL_W = 3,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              free_run,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              chan_wr,
    input  logic [CH_W-1:0]   chan_in,
    input  logic              dis_wr,
    input  logic [NCH-1:0]    dis_in,
    input  logic [RES_W-1:0]  ana_in,
    output logic [CH_W-1:0]   mux_sel,
    output logic [NCH-1:0]    dis_mask,
    output logic              sh_closed,
    output logic              conv_active,
    output logic              busy,
    output logic              done,
    output logic [RES_W-1:0]  result
);
    logic htick;
    logic begin_conv;

    sar_presc #(.PSEL_W(PSEL_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .en    (enable),
        .sel   (presc_sel),
        .htick (htick)
    );

    sar_seq_fsm #(.RES_W(RES_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .en          (enable),
        .start       (start),
        .free_run    (free_run),
        .htick       (htick),
        .ana_in      (ana_in),
        .busy        (busy),
        .sh_closed   (sh_closed),
        .conv_active (conv_active),
        .done        (done),
        .result      (result),
        .begin_conv  (begin_conv)
    );

    sar_chan_ctl #(.NCH(NCH), .CH_W(CH_W)) u_chan (
        .clk      (clk),
        .rst      (rst),
        .free_run (free_run),
        .load     (begin_conv),
        .chan_wr  (chan_wr),
        .chan_in  (chan_in),
        .dis_wr   (dis_wr),
        .dis_in   (dis_in),
        .mux_sel  (mux_sel),
        .dis_mask (dis_mask)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             free_run,
    input logic             busy,
    input logic             sh_closed,
    input logic             conv_active,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic [CH_W-1:0]  mux_sel
);
    // R7: completion strobe lasts one clock
    a_r7_done_one_clock: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: result moves only together with done
    a_r7_result_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

    // R5: switch open in every conversion window
    a_r5_window_opens_switch: assert property (@(posedge clk) disable iff (rst)
        conv_active |-> !sh_closed);

    // R11: abort empties the sequencer
    a_r11_abort_idles: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && !conv_active));

    // R6: free-running completion chains into a new conversion
    a_r6_free_chains: assert property (@(posedge clk) disable iff (rst)
        (done && $past(free_run) && enable) |-> busy);

    // R9: multiplexer holds through a free-running window
    a_r9_free_mux_hold: assert property (@(posedge clk) disable iff (rst)
        (free_run && $past(free_run) && conv_active && $past(conv_active)) |-> $stable(mux_sel));
endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .free_run    (free_run),
    .busy        (busy),
    .sh_closed   (sh_closed),
    .conv_active (conv_active),
    .done        (done),
    .result      (result),
    .mux_sel     (mux_sel)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int RES_W  = 10;
    localparam int PSEL_W = 3;
    localparam int CH_W   = 3;
    localparam int NVEC   = 5;

    // stimulus: prescaler select, free-run; expected: first done, free period
    localparam int V_SEL   [NVEC] = '{0, 1, 2, 3, 0};
    localparam int V_FREE  [NVEC] = '{0, 1, 0, 1, 1};
    localparam int V_FIRST [NVEC] = '{52, 102, 204, 408, 52};
    localparam int V_PER   [NVEC] = '{0, 52, 0, 208, 26};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic              start = 1'b0;
    logic              free_run = 1'b0;
    logic [PSEL_W-1:0] presc_sel = '0;
    logic              chan_wr = 1'b0;
    logic [CH_W-1:0]   chan_in = '0;
    logic              dis_wr = 1'b0;
    logic [NCH-1:0]    dis_in = '0;
    logic [RES_W-1:0]  ana_in = '0;
    logic [CH_W-1:0]   mux_sel;
    logic [NCH-1:0]    dis_mask;
    logic              sh_closed, conv_active, busy, done;
    logic [RES_W-1:0]  result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    sar_seq_top #(.NCH(NCH), .RES_W(RES_W), .PSEL_W(PSEL_W)) dut (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .free_run(free_run),
        .presc_sel(presc_sel), .chan_wr(chan_wr), .chan_in(chan_in), .dis_wr(dis_wr),
        .dis_in(dis_in), .ana_in(ana_in), .mux_sel(mux_sel), .dis_mask(dis_mask),
        .sh_closed(sh_closed), .conv_active(conv_active), .busy(busy), .done(done),
        .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts falling edges until done is seen; lowers start after the first
    task automatic wait_done(input int limit, output int n);
        n = -1;
        for (int k = 1; k <= limit && n < 0; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (done) n = k;
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable = 1'b0;
        start  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int k0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(!busy && !done && !sh_closed && !conv_active, "R12 control", int'(busy), 0);
        check(result == '0 && mux_sel == '0 && dis_mask == '0, "R12 data", int'(result), 0);

        // table: R1 R2 R3 R6 across prescaler settings
        for (int v = 0; v < NVEC; v++) begin
            presc_sel = PSEL_W'(V_SEL[v]);
            free_run  = V_FREE[v][0];
            enable = 1'b1;
            start  = 1'b1;
            wait_done(1000, n);
            check(n == V_FIRST[v], "R1 R2 first latency", n, V_FIRST[v]);
            if (V_FREE[v] != 0) begin
                wait_done(1000, n);
                check(n == V_PER[v], "R6 free period", n, V_PER[v]);
            end
            go_idle();
        end

        // R4 R7 first conversion schedule at divide by 2
        presc_sel = '0;
        free_run  = 1'b0;
        ana_in    = 10'h155;
        enable = 1'b1;
        start  = 1'b1;
        for (int k = 1; k <= 53; k++) begin
            bit esh, ecv, edn;
            @(negedge clk);
            if (k == 1) start = 1'b0;
            k0  = k - 2;
            esh = (k0 >= 1 && k0 <= 3) || (k0 >= 26 && k0 <= 27) || (k >= 52);
            ecv = (k >= 30 && k <= 51);
            edn = (k == 52);
            check(sh_closed == esh, "R4 switch", int'(sh_closed), int'(esh));
            check(conv_active == ecv, "R4 window", int'(conv_active), int'(ecv));
            check(done == edn, "R7 done pulse", int'(done), int'(edn));
            if (k == 35) ana_in = 10'h0AA;
            if (k == 52) check(result == 10'h155, "R7 held value", int'(result), 'h155);
        end

        // R5 R3 R8 R9 normal single conversion
        start = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            bit esh, ecv, edn;
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                check(busy == 1'b1, "R3 accepted", int'(busy), 1);
            end
            esh = !(k >= 6 && k <= 27);
            ecv = (k >= 6 && k <= 27);
            edn = (k == 28);
            check(sh_closed == esh, "R5 switch", int'(sh_closed), int'(esh));
            check(conv_active == ecv, "R5 window", int'(conv_active), int'(ecv));
            check(done == edn, "R5 done", int'(done), int'(edn));
            if (k == 10) start = 1'b1;
            if (k == 11) start = 1'b0;
            if (k == 13) begin
                check(mux_sel == 3'd5, "R9 single write", int'(mux_sel), 5);
                chan_wr = 1'b0;
            end
            if (k == 12) begin
                chan_in = 3'd5;
                chan_wr = 1'b1;
            end
            if (k == 28) check(result == 10'h0AA, "R7 second value", int'(result), 'h0AA);
        end
        wait_done(60, n);
        check(n == -1, "R8 start while busy ignored", n, -1);

        // R9 free-running channel update
        go_idle();
        free_run = 1'b1;
        enable = 1'b1;
        start  = 1'b1;
        wait_done(200, n);
        check(n == 52, "R9 free first", n, 52);
        repeat (5) @(negedge clk);
        chan_in = 3'd2;
        chan_wr = 1'b1;
        @(negedge clk);
        chan_wr = 1'b0;
        check(mux_sel == 3'd5, "R9 free write held", int'(mux_sel), 5);
        wait_done(100, n);
        check(n == 20, "R6 free spacing", n, 20);
        check(mux_sel == 3'd2, "R9 free write applied", int'(mux_sel), 2);

        // R11 abort
        go_idle();
        free_run = 1'b0;
        enable = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(!busy && !sh_closed && !conv_active, "R11 abort idle", int'(busy), 0);
        wait_done(60, n);
        check(n == -1, "R11 no done after abort", n, -1);
        enable = 1'b1;
        start  = 1'b1;
        wait_done(100, n);
        check(n == 52, "R11 first again", n, 52);

        // R10 mask register
        @(negedge clk);
        dis_in = 8'hA5;
        dis_wr = 1'b1;
        @(negedge clk);
        dis_wr = 1'b0;
        dis_in = 8'h3C;
        check(dis_mask == 8'hA5, "R10 mask load", int'(dis_mask), 'hA5);
        repeat (3) @(negedge clk);
        check(dis_mask == 8'hA5, "R10 mask hold", int'(dis_mask), 'hA5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule